// File: doc/BRIEF.md
# Timer Input Glitch Filter

This block cleans up one asynchronous timer input before an edge detector, trigger selector or capture stage uses it. The raw pin is first brought into the clock domain by a short synchronizer chain. The synchronized level is then sampled at a programmable rate. The filtered output changes only after a programmed number of consecutive samples all disagree with the present output. When the output changes, a one-cycle pulse appears on the rising-edge or falling-edge strobe.

A single 4-bit filter code chooses both the sampling divisor and the number of agreeing samples needed. A 2-bit clock-division code sets the base sampling period that the divided codes build on. The same block serves an external trigger input and each capture input. Polarity selection and what the edges are used for are left to the surrounding logic.

Top module: `tin_glitch_filter`

## Requirements
- R1: While `rst_n` is low, `level_o`, `rise_o` and `fall_o` are low, whatever `raw_i` does. An active-low reset also forces them low immediately during operation.
- R2: For filter codes 1, 2 and 3, the synchronized input is sampled on every clock and 2, 4 and 8 agreeing samples are needed. A change on `raw_i` that is held steady shows up on `level_o` exactly 2+N clock edges after it is applied. Two of those edges are the synchronizer.
- R3: Filter code 0 needs one sample and samples once per base period. With clock division 0, a held change reaches `level_o` 3 edges after it is applied.
- R4: Codes 4 to 15 sample once every base period × D and need N samples. The code-to-(D, N) mapping is: 4→(2,6), 5→(2,8), 6→(4,6), 7→(4,8), 8→(8,6), 9→(8,8), 10→(16,5), 11→(16,6), 12→(16,8), 13→(32,5), 14→(32,6), 15→(32,8).
- R5: The base period is set by `clk_div_i`: 0→1 clock, 1→2 clocks, 2→4 clocks, 3→1 clock. Codes 1 to 3 ignore this setting.
- R6: Any sample that equals the present `level_o` clears the agreement count. A run that is interrupted by even one such sample does not change the output.
- R7: With sample period P and count N, an input pulse lasting (N-1)·P clocks or less never changes `level_o`. A pulse lasting N·P clocks or more always changes it, and the output returns once the input has settled back.
- R8: `rise_o` is high for exactly the one cycle in which `level_o` goes from 0 to 1. `fall_o` is high for exactly the one cycle in which `level_o` goes from 1 to 0. The two are never high together.
- R9: `level_o` never changes without the matching edge strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raw_i | input | 1 | Unsynchronized timer input |
| filt_code_i | input | 4 | Filter code selecting sample divisor and agreement count |
| clk_div_i | input | 2 | Base sampling period select |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle strobe on filtered rising edge |
| fall_o | output | 1 | One-cycle strobe on filtered falling edge |

## Verification
Held steps with the every-clock codes measure the exact latency, which separates the synchronizer depth from the agreement count. For every filter code, pulses of width (N-1)·P and N·P are applied. The first must be rejected and the second accepted whatever the divider phase, so a wrong divisor, base period or count changes the result. A broken run, where the input stays high except for one low sample, shows whether the count is cleared rather than held. A reset applied while the output is high shows that the reset acts asynchronously.

// File: rtl/tgf_pkg.sv
package tgf_pkg;

  localparam int TGF_CODE_W     = 4;
  localparam int TGF_CKD_W      = 2;
  localparam int TGF_SHIFT_W    = 3;   // log2 of the code divisor, up to 5
  localparam int TGF_NEED_W     = 4;   // agreement count, up to 8
  localparam int TGF_MAX_SHIFT  = 5;
  localparam int TGF_MAX_BASE_L = 2;   // base period up to 4 clocks
  localparam int TGF_CNT_W      = TGF_MAX_SHIFT + TGF_MAX_BASE_L;

  typedef struct packed {
    logic                   fast;   // sample on every clock, base ignored
    logic [TGF_SHIFT_W-1:0] shift;  // divisor = 2**shift over base period
    logic [TGF_NEED_W-1:0]  need;   // samples that must agree
  } tgf_cfg_t;

  function automatic tgf_cfg_t tgf_decode(input logic [TGF_CODE_W-1:0] code);
    tgf_cfg_t c;
    c.fast  = 1'b0;
    c.shift = '0;
    c.need  = 4'd1;
    case (code)
      4'd0:  begin c.need = 4'd1; end
      4'd1:  begin c.fast = 1'b1; c.need = 4'd2; end
      4'd2:  begin c.fast = 1'b1; c.need = 4'd4; end
      4'd3:  begin c.fast = 1'b1; c.need = 4'd8; end
      4'd4:  begin c.shift = 3'd1; c.need = 4'd6; end
      4'd5:  begin c.shift = 3'd1; c.need = 4'd8; end
      4'd6:  begin c.shift = 3'd2; c.need = 4'd6; end
      4'd7:  begin c.shift = 3'd2; c.need = 4'd8; end
      4'd8:  begin c.shift = 3'd3; c.need = 4'd6; end
      4'd9:  begin c.shift = 3'd3; c.need = 4'd8; end
      4'd10: begin c.shift = 3'd4; c.need = 4'd5; end
      4'd11: begin c.shift = 3'd4; c.need = 4'd6; end
      4'd12: begin c.shift = 3'd4; c.need = 4'd8; end
      4'd13: begin c.shift = 3'd5; c.need = 4'd5; end
      4'd14: begin c.shift = 3'd5; c.need = 4'd6; end
      default: begin c.shift = 3'd5; c.need = 4'd8; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tgf_sync.sv
module tgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d_i;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tgf_rate_gen.sv
module tgf_rate_gen
  import tgf_pkg::*;
#(
  parameter int CNT_W = TGF_CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tgf_cfg_t             cfg_i,
  input  logic [TGF_CKD_W-1:0] ckd_i,
  output logic                 tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic [2:0]       base_log;

  // base period exponent; the reserved setting falls back to one clock
  always_comb begin
    case (ckd_i)
      2'd1:    base_log = 3'd1;
      2'd2:    base_log = 3'd2;
      default: base_log = 3'd0;
    endcase
  end

  always_comb begin
    if (cfg_i.fast) begin
      limit = '0;
    end else begin
      limit = CNT_W'((32'd1 << (32'(base_log) + 32'(cfg_i.shift))) - 32'd1);
    end
  end

  // ">=" lets a shortened period take effect without a long wrap
  assign tick_o = (cnt_q >= limit);

  always_comb begin
    if (tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tgf_vote.sv
module tgf_vote #(
  parameter int NEED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sample_i,
  input  logic [NEED_W-1:0] need_i,
  output logic              level_o,
  output logic              rise_o,
  output logic              fall_o
);

  logic [NEED_W-1:0] run_q, run_d;
  logic              lvl_q, lvl_d;
  logic              rise_q, rise_d;
  logic              fall_q, fall_d;
  logic [NEED_W-1:0] run_inc;

  assign run_inc = run_q + NEED_W'(1);

  always_comb begin
    run_d  = run_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (tick_i) begin
      if (sample_i == lvl_q) begin
        run_d = '0;
      end else if (run_inc >= need_i) begin
        run_d  = '0;
        lvl_d  = sample_i;
        rise_d = sample_i;
        fall_d = !sample_i;
      end else begin
        run_d = run_inc;
      end
    end
  end

  // counter and level only move on a sample tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (tick_i) begin
      run_q <= run_d;
      lvl_q <= lvl_d;
    end
  end

  // strobes are rewritten every cycle so they last one clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

endmodule

// File: rtl/tin_glitch_filter.sv
module tin_glitch_filter
  import tgf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  raw_i,
  input  logic [TGF_CODE_W-1:0] filt_code_i,
  input  logic [TGF_CKD_W-1:0]  clk_div_i,
  output logic                  level_o,
  output logic                  rise_o,
  output logic                  fall_o
);

  logic     sync_lvl;
  logic     tick;
  tgf_cfg_t cfg;

  assign cfg = tgf_decode(filt_code_i);

  tgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_i),
    .q_o   (sync_lvl)
  );

  tgf_rate_gen #(.CNT_W(TGF_CNT_W)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_i  (cfg),
    .ckd_i  (clk_div_i),
    .tick_o (tick)
  );

  tgf_vote #(.NEED_W(TGF_NEED_W)) u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .sample_i (sync_lvl),
    .need_i   (cfg.need),
    .level_o  (level_o),
    .rise_o   (rise_o),
    .fall_o   (fall_o)
  );

endmodule

// File: rtl/tgf_checker.sv
module tgf_checker (
  input logic clk,
  input logic rst_n,
  input logic level,
  input logic rise,
  input logic fall
);

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

  a_r8_rise_marks_up: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (level && !$past(level)));

  a_r8_fall_marks_down: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level)));

  a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  a_r9_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> (rise || fall));

endmodule

bind tin_glitch_filter tgf_checker u_tgf_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .level (level_o),
  .rise  (rise_o),
  .fall  (fall_o)
);

// File: tb/sim_tin_glitch_filter.sv
`timescale 1ns/1ps
module sim_tin_glitch_filter;

  logic       clk;
  logic       rst_n;
  logic       raw;
  logic [3:0] code;
  logic [1:0] ckd;
  logic       level, rise, fall;

  int n_chk  = 0;
  int n_fail = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;

  tin_glitch_filter u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_i       (raw),
    .filt_code_i (code),
    .clk_div_i   (ckd),
    .level_o     (level),
    .rise_o      (rise),
    .fall_o      (fall)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rise) rise_cnt <= rise_cnt + 1;
    if (fall) fall_cnt <= fall_cnt + 1;
  end

  // code, clock division, expected sample period, expected agreement count
  typedef struct packed { logic [3:0] c; logic [1:0] d; int unsigned p; int unsigned n; } vec_t;
  localparam vec_t VECS [16] = '{
    '{4'd0,  2'd1, 2,   1}, '{4'd1,  2'd0, 1,   2},
    '{4'd2,  2'd2, 1,   4}, '{4'd3,  2'd1, 1,   8},
    '{4'd4,  2'd3, 2,   6}, '{4'd5,  2'd1, 4,   8},
    '{4'd6,  2'd0, 4,   6}, '{4'd7,  2'd1, 8,   8},
    '{4'd8,  2'd2, 32,  6}, '{4'd9,  2'd0, 8,   8},
    '{4'd10, 2'd1, 32,  5}, '{4'd11, 2'd0, 16,  6},
    '{4'd12, 2'd2, 64,  8}, '{4'd13, 2'd0, 32,  5},
    '{4'd14, 2'd1, 64,  6}, '{4'd15, 2'd2, 128, 8}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int r0, f0;
    raw = 1'b0; code = 4'd0; ckd = 2'd0; rst_n = 1'b0;
    step(3);
    check("R1 reset level", level, 0);
    check("R1 reset rise", rise, 0);
    check("R1 reset fall", fall, 0);
    raw = 1'b1;
    step(4);
    check("R1 level under reset with input high", level, 0);
    raw = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(5);
    check("R1 level after release", level, 0);

    // R2: exact latency for every-clock codes
    for (int k = 1; k <= 3; k++) begin
      int n;
      n = 1 << k;
      code = 4'(k); ckd = 2'd2;
      step(4);
      raw = 1'b1;
      step(1 + n);
      check("R2 level one edge early", level, 0);
      step(1);
      check("R2 level on time", level, 1);
      check("R8 rise with level", rise, 1);
      step(1);
      check("R8 rise lasts one cycle", rise, 0);
      raw = 1'b0;
      step(1 + n);
      check("R2 fall one edge early", level, 1);
      step(1);
      check("R2 fall on time", level, 0);
      check("R8 fall with level", fall, 1);
      check("R8 no rise during fall", rise, 0);
      step(1);
      check("R8 fall lasts one cycle", fall, 0);
    end

    // R3: pass-through code at undivided base rate
    code = 4'd0; ckd = 2'd0;
    step(4);
    raw = 1'b1;
    step(2);
    check("R3 level before third edge", level, 0);
    step(1);
    check("R3 level after third edge", level, 1);
    raw = 1'b0;
    step(4);
    check("R3 level follows low", level, 0);

    // R6: one agreeing sample clears the run
    code = 4'd3; ckd = 2'd0;
    step(12);
    r0 = rise_cnt;
    raw = 1'b1; step(7);
    raw = 1'b0; step(1);
    raw = 1'b1; step(7);
    raw = 1'b0; step(14);
    check("R6 broken run gives no rise", rise_cnt - r0, 0);
    check("R6 broken run level", level, 0);

    // R4 R5 R7: table of codes and divisions
    foreach (VECS[i]) begin
      int unsigned p, n, settle;
      code = VECS[i].c; ckd = VECS[i].d;
      p = VECS[i].p; n = VECS[i].n;
      settle = n * p + 2 * p + 8;
      raw = 1'b0;
      step(int'(settle));
      if (n > 1) begin
        r0 = rise_cnt;
        raw = 1'b1; step(int'((n - 1) * p));
        raw = 1'b0; step(int'(settle));
        check($sformatf("R7 R4 R5 code %0d short pulse rejected", VECS[i].c), rise_cnt - r0, 0);
        check($sformatf("R7 code %0d level after short pulse", VECS[i].c), level, 0);
      end
      r0 = rise_cnt; f0 = fall_cnt;
      raw = 1'b1; step(int'(n * p));
      raw = 1'b0; step(int'(settle));
      check($sformatf("R7 R4 R5 code %0d long pulse rises", VECS[i].c), rise_cnt - r0, 1);
      check($sformatf("R7 code %0d falls back", VECS[i].c), fall_cnt - f0, 1);
      check($sformatf("R7 code %0d final level", VECS[i].c), level, 0);
    end

    // R1: reset in the middle of operation drops the output at once
    code = 4'd1; ckd = 2'd0;
    raw = 1'b1;
    step(6);
    check("R1 level high before reset", level, 1);
    rst_n = 1'b0;
    #1;
    check("R1 asynchronous reset level", level, 0);
    raw = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(4);
    check("R1 level stays low after reset", level, 0);

    summary();
  end

endmodule